// File: doc/BRIEF.md
# Lockable Two-Stage Watchdog Timer

This peripheral guards a system against software that stops running. Software programs a period value and turns the timer on. A down-counter then steps once every sixteen bus clocks. The first time the count expires, the block raises an interrupt and starts the countdown again. If software has not serviced the interrupt by the time the count expires a second time, the block pulses a system reset output. The worst-case time from the last service to reset is therefore two full periods.

Every configuration register is protected against stray writes. Writing a 32-bit key to a guard register opens the write path. Writing any other value to the guard register closes it again. While the path is closed, writes to the period, control and service registers are dropped. Reads are always allowed. The bus is a plain single-cycle interface: address, write strobe, write data, and combinational read data.

A typical driver does the following:
- To start the timer: open the guard, write the period, service any pending interrupt, enable the counter and reset, then close the guard.
- To service the timer: open the guard, write the service register, then close the guard.

Top module: `lockwd_top`

## Requirements
- R1: After reset, the period register (offset 0x000) reads 0xFFFFFFFF and the control register (0x008) reads 0. The guard register (0xC00) reads 0, meaning unlocked. The interrupt and system reset outputs are low.
- R2: Writing exactly 0x1ACCE551 to the guard register opens the write path, and the guard register then reads 0. Writing any other value closes the path, and the guard register then reads 1 in bit 0. All other bits of the guard register read 0.
- R3: While the write path is closed, writes to the period, control and service (0x00C) registers have no effect. Register contents, the pending interrupt and the countdown are all unchanged.
- R4: The period register reads back its full 32-bit value. Control bit 0 is the run/interrupt enable and bit 1 is the reset enable. Control reads back only these two bits; all other bits read 0.
- R5: A write to the period register (or to the service register) while running loads the counter with the period value N and restarts the divide-by-16 prescaler. The counter then steps once every 16 clocks. The first expiry happens exactly (N+1)*16 clocks after the write edge, and the interrupt output goes high at that point.
- R6: The interrupt output equals the pending flag ANDed with control bit 0. Changing control bit 0 does not alter the pending flag.
- R7: On an expiry that finds the interrupt already pending, the block emits a one-clock high pulse on the system reset output if control bit 1 is set, and no pulse if it is clear. With no service, this pulse comes 2*(N+1)*16 clocks after the load.
- R8: Any write to the service register clears the pending interrupt on the next clock and reloads the counter. Servicing more often than once per period keeps both outputs low.
- R9: Writing 0 to the control register stops the countdown. No interrupt or reset then appears, however long the timer stays stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Watchdog interrupt, high while pending and enabled |
| sysrst_o | output | 1 | One-clock system reset pulse |

## Verification
The embedded assertions check several properties on every cycle:
- Dropped writes leave the period and control registers unchanged, and the counter moves only on a prescaler tick or a load.
- The prescaler never ticks on two adjacent cycles.
- A reset pulse is always a single cycle, and is always preceded by a pending interrupt with the reset enable set.
- A service always clears the pending flag.
- The interrupt never shows while control bit 0 is clear.

Only the bench scenarios can show the exact expiry cycles for each period value. The same holds for keeping reset quiet under periodic service, and for the stop behaviour over long intervals.

// File: rtl/lockwd_pkg.sv
package lockwd_pkg;

    localparam int unsigned ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFS_PERIOD = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_SVC    = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_GUARD  = 12'hC00;

    localparam logic [31:0] GUARD_KEY = 32'h1ACC_E551;

    typedef struct packed {
        logic rst_en;
        logic run;
    } ctrl_t;

endpackage

// File: rtl/lockwd_prescale.sv
module lockwd_prescale #(
    parameter int unsigned DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic restart_i,
    output logic tick_o
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_t;

    pre_t pre_d, pre_q;

    assign tick_o = run_i && (pre_q.cnt == LAST);

    always_comb begin
        pre_d = pre_q;
        if (!run_i || restart_i || tick_o) begin
            pre_d.cnt = '0;
        end else begin
            pre_d.cnt = pre_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end

    generate
        if (DIV > 1) begin : g_tick_chk
            // R5
            tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o)
                else $error("prescaler ticked on adjacent cycles");
        end
    endgenerate

endmodule

// File: rtl/lockwd_regs.sv
module lockwd_regs
    import lockwd_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [DW-1:0]     wdata_i,
    output logic [DW-1:0]     rdata_o,
    output logic [DW-1:0]     period_o,
    output ctrl_t             ctrl_o,
    output logic              load_o,
    output logic [DW-1:0]     load_val_o,
    output logic              svc_o
);
    typedef struct packed {
        logic [DW-1:0] period;
        ctrl_t         ctrl;
        logic          locked;
    } regs_t;

    regs_t r_d, r_q;

    logic wr_period, wr_ctrl, wr_svc, wr_guard, open_wr;

    always_comb begin
        open_wr   = !r_q.locked;
        wr_period = we_i && open_wr && (addr_i == OFS_PERIOD);
        wr_ctrl   = we_i && open_wr && (addr_i == OFS_CTRL);
        wr_svc    = we_i && open_wr && (addr_i == OFS_SVC);
        wr_guard  = we_i && (addr_i == OFS_GUARD);
    end

    always_comb begin
        r_d = r_q;
        if (wr_period) begin
            r_d.period = wdata_i;
        end
        if (wr_ctrl) begin
            r_d.ctrl.run    = wdata_i[0];
            r_d.ctrl.rst_en = wdata_i[1];
        end
        if (wr_guard) begin
            r_d.locked = (wdata_i != DW'(GUARD_KEY));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.period <= '1;
            r_q.ctrl   <= '0;
            r_q.locked <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            OFS_PERIOD: rdata_o = r_q.period;
            OFS_CTRL:   rdata_o = DW'({r_q.ctrl.rst_en, r_q.ctrl.run});
            OFS_GUARD:  rdata_o = DW'(r_q.locked);
            default:    rdata_o = '0;
        endcase
    end

    assign period_o   = r_q.period;
    assign ctrl_o     = r_q.ctrl;
    assign svc_o      = wr_svc;
    assign load_o     = wr_period || wr_svc;
    assign load_val_o = wr_period ? wdata_i : r_q.period;

    // R3
    locked_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.locked && we_i && addr_i == OFS_PERIOD) |=> $stable(period_o))
        else $error("period changed while locked");

    // R3
    locked_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.locked && we_i && addr_i == OFS_CTRL) |=> $stable(ctrl_o))
        else $error("control changed while locked");

endmodule

// File: rtl/lockwd_core.sv
module lockwd_core #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          rst_en_i,
    input  logic          tick_i,
    input  logic          load_i,
    input  logic [DW-1:0] load_val_i,
    input  logic [DW-1:0] period_i,
    input  logic          svc_i,
    output logic          pend_o,
    output logic          sysrst_o
);
    typedef struct packed {
        logic [DW-1:0] cnt;
        logic          pend;
        logic          rst;
    } core_t;

    core_t c_d, c_q;

    always_comb begin
        c_d     = c_q;
        c_d.rst = 1'b0;
        if (load_i) begin
            c_d.cnt = load_val_i;
            if (svc_i) begin
                c_d.pend = 1'b0;
            end
        end else if (run_i && tick_i) begin
            if (c_q.cnt == '0) begin
                c_d.cnt = period_i;
                if (c_q.pend) begin
                    c_d.rst = rst_en_i;
                end else begin
                    c_d.pend = 1'b1;
                end
            end else begin
                c_d.cnt = c_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.cnt  <= '1;
            c_q.pend <= 1'b0;
            c_q.rst  <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign pend_o   = c_q.pend;
    assign sysrst_o = c_q.rst;

    // R5
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_i) |=> $stable(c_q.cnt))
        else $error("counter moved without tick or load");

    // R7
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sysrst_o |=> !sysrst_o)
        else $error("reset held longer than one clock");

    // R7
    rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sysrst_o) |-> ($past(pend_o) && $past(rst_en_i)))
        else $error("reset without pending interrupt and enable");

    // R8
    svc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_i |=> !pend_o)
        else $error("service did not clear pending flag");

endmodule

// File: rtl/lockwd_top.sv
module lockwd_top
    import lockwd_pkg::*;
#(
    parameter int unsigned DW  = 32,
    parameter int unsigned DIV = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [11:0]   bus_addr,
    input  logic          bus_we,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq_o,
    output logic          sysrst_o
);
    logic [DW-1:0] period;
    ctrl_t         ctrl;
    logic          load;
    logic [DW-1:0] load_val;
    logic          svc;
    logic          tick;
    logic          pend;

    lockwd_regs #(.DW(DW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (bus_addr),
        .we_i       (bus_we),
        .wdata_i    (bus_wdata),
        .rdata_o    (bus_rdata),
        .period_o   (period),
        .ctrl_o     (ctrl),
        .load_o     (load),
        .load_val_o (load_val),
        .svc_o      (svc)
    );

    lockwd_prescale #(.DIV(DIV)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (ctrl.run),
        .restart_i (load),
        .tick_o    (tick)
    );

    lockwd_core #(.DW(DW)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (ctrl.run),
        .rst_en_i   (ctrl.rst_en),
        .tick_i     (tick),
        .load_i     (load),
        .load_val_i (load_val),
        .period_i   (period),
        .svc_i      (svc),
        .pend_o     (pend),
        .sysrst_o   (sysrst_o)
    );

    assign irq_o = pend && ctrl.run;

    // R6
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ctrl.run)
        else $error("interrupt shown while disabled");

endmodule

// File: tb/lockwd_top_test.sv
module lockwd_top_test;
    localparam int DIV = 16;
    localparam logic [11:0] A_PER = 12'h000, A_CTL = 12'h008,
                            A_SVC = 12'h00C, A_GRD = 12'hC00, A_IDLE = 12'h004;
    localparam logic [31:0] KEY = 32'h1ACCE551;

    logic clk = 1'b0, rst_n = 1'b0, we = 1'b0;
    logic [11:0] addr = A_IDLE;
    logic [31:0] wdata = '0, rdata;
    logic irq, srst;
    int total = 0, bad = 0;

    always #4 clk = ~clk;

    lockwd_top #(.DW(32), .DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq), .sysrst_o(srst)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0; addr = A_IDLE;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
        addr = A_IDLE;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int p, rcount, icount;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_PER, v); chk(v == 32'hFFFFFFFF, "R1 period", v, 32'hFFFFFFFF);
        rd(A_CTL, v); chk(v == 0, "R1 ctrl", v, 0);
        rd(A_GRD, v); chk(v == 0, "R1 guard", v, 0);
        chk(irq == 0 && srst == 0, "R1 outputs", {irq, srst}, 0);

        // R4 control readback masks to two bits
        wr(A_CTL, 32'hFFFF_FFFC); rd(A_CTL, v); chk(v == 0, "R4 ctrl mask", v, 0);
        wr(A_CTL, 32'h0000_0002); rd(A_CTL, v); chk(v == 2, "R4 ctrl", v, 2);
        wr(A_CTL, 0);
        wr(A_PER, 32'hA5C3_0F96); rd(A_PER, v); chk(v == 32'hA5C3_0F96, "R4 period", v, 32'hA5C3_0F96);

        // R5 / R7 sweep of period values
        for (int n = 0; n < 8; n++) begin
            wr(A_CTL, 0);
            wr(A_SVC, 0);
            wr(A_CTL, 3);
            wr(A_PER, n);
            p = (n + 1) * DIV;
            rcount = 0;
            for (int w = 1; w <= 2 * p + 1; w++) begin
                @(negedge clk);
                if (srst) rcount++;
                if (w == p - 1) chk(irq == 0, $sformatf("R5 n=%0d before expiry", n), irq, 0);
                if (w == p)     chk(irq == 1, $sformatf("R5 n=%0d expiry", n), irq, 1);
                if (w == 2 * p - 1) chk(srst == 0, $sformatf("R7 n=%0d before reset", n), srst, 0);
                if (w == 2 * p)     chk(srst == 1, $sformatf("R7 n=%0d reset", n), srst, 1);
            end
            chk(rcount == 1, $sformatf("R7 n=%0d single pulse", n), rcount, 1);
            rd(A_PER, v); chk(v == n, "R4 period readback", v, n);
        end

        // R7 reset disabled, R6 gating
        wr(A_CTL, 0); wr(A_SVC, 0); wr(A_CTL, 1); wr(A_PER, 2);
        p = 3 * DIV;
        rcount = 0;
        for (int w = 1; w <= 3 * p; w++) begin
            @(negedge clk);
            if (srst) rcount++;
        end
        chk(rcount == 0, "R7 no reset when disabled", rcount, 0);
        chk(irq == 1, "R6 pending shown", irq, 1);
        wr(A_CTL, 2); chk(irq == 0, "R6 masked", irq, 0);
        wr(A_CTL, 1); chk(irq == 1, "R6 pending kept", irq, 1);

        // R2 / R3 guard
        wr(A_GRD, 1); rd(A_GRD, v); chk(v == 1, "R2 locked", v, 1);
        wr(A_SVC, 0); chk(irq == 1, "R3 service ignored", irq, 1);
        wr(A_PER, 9); rd(A_PER, v); chk(v == 2, "R3 period ignored", v, 2);
        wr(A_CTL, 0); rd(A_CTL, v); chk(v == 1, "R3 ctrl ignored", v, 1);
        wr(A_GRD, KEY); rd(A_GRD, v); chk(v == 0, "R2 unlocked", v, 0);
        wr(A_GRD, KEY ^ 32'h1); rd(A_GRD, v); chk(v == 1, "R2 near key locks", v, 1);
        wr(A_GRD, KEY); rd(A_GRD, v); chk(v == 0, "R2 reopen", v, 0);

        // R8 service
        wr(A_SVC, 0); chk(irq == 0, "R8 clear", irq, 0);
        wr(A_CTL, 3); wr(A_PER, 3);
        rcount = 0; icount = 0;
        for (int k = 0; k < 6; k++) begin
            for (int w = 0; w < 50; w++) begin
                @(negedge clk);
                if (srst) rcount++;
                if (irq) icount++;
            end
            wr(A_SVC, 0);
        end
        chk(icount == 0, "R8 no interrupt when serviced", icount, 0);
        chk(rcount == 0, "R8 no reset when serviced", rcount, 0);

        // R9 stop
        wr(A_PER, 1);
        wr(A_CTL, 0);
        rcount = 0; icount = 0;
        for (int w = 0; w < 400; w++) begin
            @(negedge clk);
            if (srst) rcount++;
            if (irq) icount++;
        end
        chk(icount == 0 && rcount == 0, "R9 stopped", {icount[15:0], rcount[15:0]}, 0);
        wr(A_CTL, 1);
        chk(irq == 0, "R9 no stale interrupt", irq, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule